// File: doc/BRIEF.md
# Ordered Store Queue with Load Forwarding

This block holds stores between a load/store pipeline and a single data-cache write port. Stores are allocated one per cycle in program order. Their address and data arrive later, each through its own write port, addressed by the entry id that was handed out at allocation. Committed stores leave for the cache strictly oldest first. An entry is released only when the cache acknowledges the write, so the memory state seen by the cache stays precise.

Each load is presented with an age tag and a full address. The age tag is the queue's allocation pointer at the time the load was dispatched. The block compares the load against every live store that is older than the tag, and in the same cycle it answers with exactly one of three results:
- **stall**: retry the load later.
- **forward**: take the data from the queue.
- **bypass**: read the cache.

A mispredict flush removes the stores that are not yet committed. Committed stores keep draining.

Top module: `store_load_buffer`

## Requirements
- R1: `st_full_o` is high exactly when DEPTH stores are live. An allocation request while full, or in a flush cycle, is ignored and the id it would have used is not consumed. Ids are handed out in rotating order 0,1,…,DEPTH-1.
- R2: `cw_req_o` is high only while the oldest live store is committed. It presents that store's address and data. Stores reach the port in allocation order.
- R3: A store leaves the queue only in a cycle where `cw_req_o` and `cw_ack_i` are both high. Until then its request stays asserted with the same address and data.
- R4: A valid load stalls when any store older than its tag has no valid address yet.
- R5: When all older addresses are known and at least one equals the load address, the load uses the youngest such older store. If that store has data, `ld_fwd_o` is high and `ld_fwd_data_o` carries that data.
- R6: When the youngest matching older store has no valid data yet, the load stalls.
- R7: When all older addresses are known and none matches, `ld_bypass_o` is high.
- R8: Stores at or after the load's tag are ignored by the load check. The tag is a pointer of log2(DEPTH)+1 bits, taken modulo 2·DEPTH, and must lie between the oldest live store and the allocation pointer.
- R9: `flush_i` removes every uncommitted store, and the next allocated id follows the last committed one. A commit in the same cycle is applied first. Committed stores still drain.
- R10: After reset the queue is empty: no request, not full, next id 0. Without `ld_valid_i` all three load results are low, and with it exactly one is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_alloc_i | input | 1 | Allocate the next store entry |
| st_full_o | output | 1 | Queue holds DEPTH stores |
| st_alloc_id_o | output | log2(DEPTH) | Id given to the next allocation |
| st_addr_we_i | input | 1 | Write a store address |
| st_addr_id_i | input | log2(DEPTH) | Entry receiving the address |
| st_addr_i | input | ADDR_W | Effective address |
| st_data_we_i | input | 1 | Write store data |
| st_data_id_i | input | log2(DEPTH) | Entry receiving the data |
| st_data_i | input | DATA_W | Store data |
| st_commit_i | input | 1 | Commit the oldest uncommitted store |
| flush_i | input | 1 | Discard uncommitted stores |
| ld_valid_i | input | 1 | A load is presented |
| ld_tag_i | input | log2(DEPTH)+1 | Allocation pointer at load dispatch |
| ld_addr_i | input | ADDR_W | Load address |
| ld_stall_o | output | 1 | Load must wait |
| ld_fwd_o | output | 1 | Load served from queue |
| ld_fwd_data_o | output | DATA_W | Forwarded data |
| ld_bypass_o | output | 1 | Load may read the cache |
| cw_req_o | output | 1 | Oldest committed store requests the port |
| cw_addr_o | output | ADDR_W | Address of that store |
| cw_data_o | output | DATA_W | Data of that store |
| cw_ack_i | input | 1 | Cache accepted the write |

## Verification
The load results depend only on the input pins and the registered queue state, so they are due in the same cycle as the load. The bench drives inputs after the falling edge and compares them a short delay later, well before the next rising edge. Every allocation, address or data write, commit, flush and acknowledge takes effect at the next rising edge. The reference model applies each one at that edge, and the following cycle's compare of full, id, request, address and data observes it. Because every output is compared in every cycle, a wrong result surfaces in the first cycle it appears.

// File: rtl/sb_pkg.sv
// Shared types for the store queue.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sb_pkg;
    // Outcome of the dependence check for one load.
    typedef enum logic [1:0] {
        LD_NONE   = 2'd0,
        LD_STALL  = 2'd1,
        LD_FWD    = 2'd2,
        LD_BYPASS = 2'd3
    } ld_res_e;
endpackage

// File: rtl/sb_ptr_ctrl.sv
// Head, commit and tail pointers of the circular store queue.
// Pointers carry one extra wrap bit so that full and empty differ.
// Assumes DEPTH is a power of two, at least 2.
module sb_ptr_ctrl #(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int PW = PTR_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_i,
    input  logic          commit_i,
    input  logic          flush_i,
    input  logic          ack_i,
    output logic [PW-1:0] head_o,
    output logic [PW-1:0] tail_o,
    output logic          full_o,
    output logic          alloc_ok_o,
    output logic          req_o
);
    logic [PW-1:0] head_q, cmt_q, tail_q;
    logic [PW-1:0] cmt_n;
    logic          commit_ok;

    // Derive occupancy and the accepted events of this cycle.
    always_comb begin
        full_o     = (tail_q - head_q) == PW'(DEPTH);
        req_o      = head_q != cmt_q;
        alloc_ok_o = alloc_i && !full_o && !flush_i;
        commit_ok  = commit_i && (cmt_q != tail_q);
        cmt_n      = cmt_q + PW'(commit_ok);
    end

    // Advance pointers; a flush pulls the tail back to the commit point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            cmt_q  <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_q + PW'(ack_i && req_o);
            cmt_q  <= cmt_n;
            if (flush_i) tail_q <= cmt_n;
            else         tail_q <= tail_q + PW'(alloc_ok_o);
        end
    end

    assign head_o = head_q;
    assign tail_o = tail_q;
endmodule

// File: rtl/sb_entry_store.sv
// Per-entry address, data and their valid flags.
// Allocation clears both flags. The address and data ports then fill them by id.
// Assumes a write targets a live entry and does not hit the entry being allocated that cycle.
module sb_entry_store #(
    parameter int DEPTH = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_i,
    input  logic [PTR_W-1:0]              alloc_id_i,
    input  logic                          addr_we_i,
    input  logic [PTR_W-1:0]              addr_id_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic                          data_we_i,
    input  logic [PTR_W-1:0]              data_id_i,
    input  logic [DATA_W-1:0]             data_i,
    output logic [DEPTH-1:0][ADDR_W-1:0]  addr_o,
    output logic [DEPTH-1:0]              addr_v_o,
    output logic [DEPTH-1:0][DATA_W-1:0]  data_o,
    output logic [DEPTH-1:0]              data_v_o
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Track the flags and payload of entry g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_v_o[g] <= 1'b0;
                data_v_o[g] <= 1'b0;
                addr_o[g]   <= '0;
                data_o[g]   <= '0;
            end else begin
                if (alloc_i && alloc_id_i == PTR_W'(g)) begin
                    addr_v_o[g] <= 1'b0;
                    data_v_o[g] <= 1'b0;
                end
                if (addr_we_i && addr_id_i == PTR_W'(g)) begin
                    addr_v_o[g] <= 1'b1;
                    addr_o[g]   <= addr_i;
                end
                if (data_we_i && data_id_i == PTR_W'(g)) begin
                    data_v_o[g] <= 1'b1;
                    data_o[g]   <= data_i;
                end
            end
        end
    end
endmodule

// File: rtl/sb_load_search.sv
// Combinational dependence check of one load against the older live stores.
// Walks from the oldest entry towards the tag, so the last hit is the youngest.
// Assumes the tag lies between head and tail.
module sb_load_search #(
    parameter int DEPTH = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int PW = PTR_W + 1
) (
    input  logic [PW-1:0]                 head_i,
    input  logic [PW-1:0]                 tail_i,
    input  logic [PW-1:0]                 tag_i,
    input  logic [ADDR_W-1:0]             ld_addr_i,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  addr_i,
    input  logic [DEPTH-1:0]              addr_v_i,
    input  logic [DEPTH-1:0][DATA_W-1:0]  data_i,
    input  logic [DEPTH-1:0]              data_v_i,
    output sb_pkg::ld_res_e               res_o,
    output logic [DATA_W-1:0]             fwd_data_o
);
    logic [PW-1:0]    off_tag, live;
    logic [PTR_W-1:0] idx;
    logic             unknown, hit, hit_rdy;

    // Scan older entries, remember unknown addresses and the youngest match.
    always_comb begin
        off_tag    = tag_i - head_i;
        live       = tail_i - head_i;
        unknown    = 1'b0;
        hit        = 1'b0;
        hit_rdy    = 1'b0;
        fwd_data_o = '0;
        idx        = '0;
        for (int i = 0; i < DEPTH; i++) begin
            idx = head_i[PTR_W-1:0] + PTR_W'(i);
            if (PW'(i) < off_tag && PW'(i) < live) begin
                if (!addr_v_i[idx]) begin
                    unknown = 1'b1;
                end else if (addr_i[idx] == ld_addr_i) begin
                    hit        = 1'b1;
                    hit_rdy    = data_v_i[idx];
                    fwd_data_o = data_i[idx];
                end
            end
        end
        if (unknown || (hit && !hit_rdy)) res_o = sb_pkg::LD_STALL;
        else if (hit)                     res_o = sb_pkg::LD_FWD;
        else                              res_o = sb_pkg::LD_BYPASS;
    end
endmodule

// File: rtl/store_load_buffer.sv
// In-order store queue in front of one cache write port, with load forwarding.
// Stores drain oldest first after commit and are freed only on write acknowledge.
// Assumes DEPTH is a power of two and at most one allocation, commit and write per port each cycle.
module store_load_buffer #(
    parameter int DEPTH = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int PW = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_alloc_i,
    output logic              st_full_o,
    output logic [PTR_W-1:0]  st_alloc_id_o,
    input  logic              st_addr_we_i,
    input  logic [PTR_W-1:0]  st_addr_id_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic              st_data_we_i,
    input  logic [PTR_W-1:0]  st_data_id_i,
    input  logic [DATA_W-1:0] st_data_i,
    input  logic              st_commit_i,
    input  logic              flush_i,
    input  logic              ld_valid_i,
    input  logic [PW-1:0]     ld_tag_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    output logic              ld_stall_o,
    output logic              ld_fwd_o,
    output logic [DATA_W-1:0] ld_fwd_data_o,
    output logic              ld_bypass_o,
    output logic              cw_req_o,
    output logic [ADDR_W-1:0] cw_addr_o,
    output logic [DATA_W-1:0] cw_data_o,
    input  logic              cw_ack_i
);
    logic [PW-1:0]                head, tail;
    logic                         alloc_ok;
    logic [DEPTH-1:0][ADDR_W-1:0] e_addr;
    logic [DEPTH-1:0][DATA_W-1:0] e_data;
    logic [DEPTH-1:0]             e_av, e_dv;
    sb_pkg::ld_res_e              res;

    sb_ptr_ctrl #(.DEPTH(DEPTH)) i_ptr (
        .clk(clk), .rst_n(rst_n), .alloc_i(st_alloc_i), .commit_i(st_commit_i),
        .flush_i(flush_i), .ack_i(cw_ack_i), .head_o(head), .tail_o(tail),
        .full_o(st_full_o), .alloc_ok_o(alloc_ok), .req_o(cw_req_o)
    );

    sb_entry_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ent (
        .clk(clk), .rst_n(rst_n), .alloc_i(alloc_ok), .alloc_id_i(tail[PTR_W-1:0]),
        .addr_we_i(st_addr_we_i), .addr_id_i(st_addr_id_i), .addr_i(st_addr_i),
        .data_we_i(st_data_we_i), .data_id_i(st_data_id_i), .data_i(st_data_i),
        .addr_o(e_addr), .addr_v_o(e_av), .data_o(e_data), .data_v_o(e_dv)
    );

    sb_load_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_srch (
        .head_i(head), .tail_i(tail), .tag_i(ld_tag_i), .ld_addr_i(ld_addr_i),
        .addr_i(e_addr), .addr_v_i(e_av), .data_i(e_data), .data_v_i(e_dv),
        .res_o(res), .fwd_data_o(ld_fwd_data_o)
    );

    // Qualify the load result and present the oldest entry to the cache port.
    always_comb begin
        st_alloc_id_o = tail[PTR_W-1:0];
        ld_stall_o    = ld_valid_i && (res == sb_pkg::LD_STALL);
        ld_fwd_o      = ld_valid_i && (res == sb_pkg::LD_FWD);
        ld_bypass_o   = ld_valid_i && (res == sb_pkg::LD_BYPASS);
        cw_addr_o     = e_addr[head[PTR_W-1:0]];
        cw_data_o     = e_data[head[PTR_W-1:0]];
    end
endmodule

// File: rtl/sb_checker.sv
// Temporal checks on the store queue ports, bound into every instance.
// Assumes the port names of store_load_buffer.
module sb_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush_i,
    input logic              st_commit_i,
    input logic              st_full_o,
    input logic              cw_req_o,
    input logic [ADDR_W-1:0] cw_addr_o,
    input logic [DATA_W-1:0] cw_data_o,
    input logic              cw_ack_i,
    input logic              ld_valid_i,
    input logic              ld_stall_o,
    input logic              ld_fwd_o,
    input logic              ld_bypass_o
);
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cw_req_o && !cw_ack_i |=> $stable(cw_addr_o) && $stable(cw_data_o)); // R3
    AST_REQ_SURVIVES_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        cw_req_o && !cw_ack_i |=> cw_req_o); // R9
    AST_REQ_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !cw_req_o && !st_commit_i |=> !cw_req_o); // R2
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        st_full_o && !cw_ack_i && !flush_i |=> st_full_o); // R1
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ld_stall_o, ld_fwd_o, ld_bypass_o}) == (ld_valid_i ? 1 : 0)); // R10
endmodule

bind store_load_buffer sb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_store_load_buffer.sv
// Bench: behavioural queue model compared on every cycle.
module test_store_load_buffer;
    localparam int DEPTH = 4;
    localparam int PTR_W = 2;
    localparam int AW = 32;
    localparam int DW = 32;

    typedef struct {
        int          seq;
        logic [31:0] addr;
        bit          av;
        logic [31:0] data;
        bit          dv;
        bit          cm;
    } ent_t;

    logic clk = 0, rst_n = 0;
    logic st_alloc_i = 0, st_full_o;
    logic [PTR_W-1:0] st_alloc_id_o;
    logic st_addr_we_i = 0; logic [PTR_W-1:0] st_addr_id_i = 0; logic [AW-1:0] st_addr_i = 0;
    logic st_data_we_i = 0; logic [PTR_W-1:0] st_data_id_i = 0; logic [DW-1:0] st_data_i = 0;
    logic st_commit_i = 0, flush_i = 0, ld_valid_i = 0, cw_ack_i = 0;
    logic [PTR_W:0] ld_tag_i = 0;
    logic [AW-1:0] ld_addr_i = 0;
    logic ld_stall_o, ld_fwd_o, ld_bypass_o, cw_req_o;
    logic [DW-1:0] ld_fwd_data_o, cw_data_o;
    logic [AW-1:0] cw_addr_o;

    ent_t q[$];
    int alloc_cnt = 0;
    int ld_seq = 0;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    store_load_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) i_store_load_buffer (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare all outputs against the model (called between edges).
    task automatic compare();
        bit full_e, req_e, stall_e, fwd_e, byp_e, unk, hit, hrdy;
        logic [31:0] hdata;
        full_e = (q.size() == DEPTH);
        chk("R1", "full", 32'(st_full_o), 32'(full_e));
        chk("R1", "alloc id", 32'(st_alloc_id_o), 32'(alloc_cnt % DEPTH));
        req_e = (q.size() > 0) && q[0].cm;
        chk("R2", "req", 32'(cw_req_o), 32'(req_e));
        if (req_e) begin
            chk("R2", "cw addr", cw_addr_o, q[0].addr);
            chk("R2", "cw data", cw_data_o, q[0].data);
        end
        unk = 0; hit = 0; hrdy = 0; hdata = 0;
        foreach (q[k]) if (q[k].seq < ld_seq) begin
            if (!q[k].av) unk = 1;
            else if (q[k].addr == ld_addr_i) begin hit = 1; hrdy = q[k].dv; hdata = q[k].data; end
        end
        stall_e = ld_valid_i && (unk || (hit && !hrdy));
        fwd_e   = ld_valid_i && !stall_e && hit;
        byp_e   = ld_valid_i && !stall_e && !hit;
        if (!ld_valid_i) begin
            chk("R10", "idle results", 32'({ld_stall_o, ld_fwd_o, ld_bypass_o}), 0);
        end else begin
            chk(unk ? "R4" : "R6", "stall", 32'(ld_stall_o), 32'(stall_e));
            chk("R5", "fwd", 32'(ld_fwd_o), 32'(fwd_e));
            if (fwd_e) chk("R5", "fwd data", ld_fwd_data_o, hdata);
            chk("R7", "bypass", 32'(ld_bypass_o), 32'(byp_e));
        end
    endtask

    // Apply the edge's effects to the model, in the block's order.
    task automatic model_edge();
        bit was_full;
        int k;
        was_full = (q.size() == DEPTH);
        if (cw_ack_i && q.size() > 0 && q[0].cm) void'(q.pop_front()); // R3
        foreach (q[j]) begin
            if (st_addr_we_i && (q[j].seq % DEPTH) == st_addr_id_i) begin q[j].addr = st_addr_i; q[j].av = 1; end
            if (st_data_we_i && (q[j].seq % DEPTH) == st_data_id_i) begin q[j].data = st_data_i; q[j].dv = 1; end
        end
        if (st_commit_i) begin
            k = -1;
            foreach (q[j]) if (k < 0 && !q[j].cm) k = j;
            if (k >= 0) q[k].cm = 1;
        end
        if (flush_i) begin // R9
            while (q.size() > 0 && !q[$].cm) begin void'(q.pop_back()); alloc_cnt--; end
        end else if (st_alloc_i && !was_full) begin
            q.push_back('{seq: alloc_cnt, addr: 0, av: 0, data: 0, dv: 0, cm: 0});
            alloc_cnt++;
        end
    endtask

    task automatic tick();
        ld_tag_i = ld_seq[PTR_W:0];
        #2 compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        st_alloc_i = 0; st_addr_we_i = 0; st_data_we_i = 0;
        st_commit_i = 0; flush_i = 0; ld_valid_i = 0; cw_ack_i = 0;
        ld_seq = alloc_cnt;
    endtask

    task automatic set_addr(input int seq, input logic [31:0] a);
        st_addr_we_i = 1; st_addr_id_i = PTR_W'(seq % DEPTH); st_addr_i = a;
    endtask
    task automatic set_data(input int seq, input logic [31:0] d);
        st_data_we_i = 1; st_data_id_i = PTR_W'(seq % DEPTH); st_data_i = d;
    endtask
    task automatic load(input int seq, input logic [31:0] a);
        ld_valid_i = 1; ld_seq = seq; ld_addr_i = a;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        tick(); // R10 reset state
        st_alloc_i = 1; tick();
        st_alloc_i = 1; tick();
        load(2, 32'h100); tick();                         // R4 unknown addresses
        set_addr(0, 32'h100); tick();
        set_addr(1, 32'h200); load(2, 32'h300); tick();   // R4 one still unknown
        load(2, 32'h300); tick();                         // R7 bypass
        load(2, 32'h100); tick();                         // R6 no data yet
        set_data(0, 32'hAAAA); tick();
        load(2, 32'h100); tick();                         // R5 forward
        st_alloc_i = 1; set_data(1, 32'hBBBB); tick();
        set_addr(2, 32'h100); tick();
        set_data(2, 32'hCCCC); tick();
        load(3, 32'h100); tick();                         // R5 youngest wins
        load(2, 32'h100); tick();                         // R8 younger store ignored
        load(1, 32'h200); tick();                         // R8 bypass past younger
        st_alloc_i = 1; tick();                           // R1 becomes full
        st_alloc_i = 1; set_addr(3, 32'h400); tick();     // R1 ignored when full
        set_data(3, 32'hDDDD); load(1, 32'h100); tick();
        st_commit_i = 1; tick();
        st_commit_i = 1; tick();                          // R2 request appears
        tick(); tick();                                   // R3 held without ack
        flush_i = 1; st_alloc_i = 1; tick();              // R9 drop uncommitted
        cw_ack_i = 1; tick();
        tick();
        cw_ack_i = 1; tick();
        tick();
        // R9 commit and flush in the same cycle
        st_alloc_i = 1; tick();
        st_alloc_i = 1; set_addr(alloc_cnt - 1, 32'h500); tick();
        set_addr(alloc_cnt - 1, 32'h600); set_data(alloc_cnt - 2, 32'h55); tick();
        set_data(alloc_cnt - 1, 32'h66); tick();
        st_commit_i = 1; flush_i = 1; tick();
        cw_ack_i = 1; tick();
        // wrap-around traffic with forwarding across the pointer wrap
        for (int r = 0; r < 12; r++) begin
            st_alloc_i = 1; tick();
            set_addr(alloc_cnt - 1, 32'h40 + 32'(r % 3)); set_data(alloc_cnt - 1, 32'h1000 + 32'(r)); tick();
            load(alloc_cnt, 32'h40 + 32'(r % 3)); tick();
            load(alloc_cnt, 32'h80); st_commit_i = 1; tick();
            if (r % 2 == 1) begin
                cw_ack_i = 1; tick();
                cw_ack_i = 1; tick();
            end
        end
        for (int d = 0; d < 6; d++) begin cw_ack_i = 1; tick(); end
        tick();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule